// File: doc/BRIEF.md
# Preloadable Timer Square-Wave Divider

This block is an up-counting timer that restarts from a programmable start value each time it wraps. Every wrap flips a toggle flip-flop, so the toggle produces a square wave at half the wrap rate. With a start value N and a counter of M states (M = 2^CNT_W), the wave frequency is the tick rate divided by 2×(M−N).

An output multiplexer decides what reaches the pin. With the divider option off, the pin follows a port data bit. With the option on, the port data bit acts as a gate. A 1 passes the square wave and a 0 holds the pin low. The counter advances only on cycles where the tick enable is high and the run control is set. The start value is held in a register. A write while the timer is stopped also loads the counter. A write while it runs is used only at the next wrap.

Top module: `pfd_divider`

## Requirements
- R1: While rst is high at a clock edge, tmr_count, ovf_pulse and pin_out all become 0, and the stored start value clears to 0.
- R2: With run high and tick high, tmr_count rises by exactly one per clock unless it holds all ones. With tick low, tmr_count does not change.
- R3: With run and tick high and tmr_count all ones, the next tmr_count is the stored start value, never zero on the way, unless the start value is zero. ovf_pulse is 1 in the cycle after that edge and 0 otherwise.
- R4: The internal toggle flips at each wrap, so with div_en=1, port_bit=1 and tick always high, pin_out has a period of 2×(2^CNT_W − N) clocks.
- R5: With run low, tmr_count and the toggle hold their values unless a start-value write occurs.
- R6: A start-value write (pre_we=1) while run is high leaves tmr_count on its normal path. The new value is loaded at the next wrap. A wrap in the same cycle as the write still uses the old value.
- R7: A start-value write while run is low loads pre_data into tmr_count on the next clock.
- R8: With div_en=0, pin_out equals the port_bit value from the previous clock.
- R9: With div_en=1 and port_bit=1, pin_out equals the toggle state of the previous clock.
- R10: With div_en=1 and port_bit=0, pin_out is 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer input clock enable |
| run | input | 1 | Timer run control |
| div_en | input | 1 | Selects the divider wave as the pin source |
| port_bit | input | 1 | Port data bit (plain output or wave gate) |
| pre_we | input | 1 | Start-value write strobe |
| pre_data | input | CNT_W | Start value to write |
| pin_out | output | 1 | Registered pin drive |
| tmr_count | output | CNT_W | Current timer value |
| ovf_pulse | output | 1 | One-clock registered wrap indication |

## Verification
The bench aims at the wrap edge. It checks that the all-ones count goes straight to the start value. A design that passed through zero would stretch each half period by one tick and show the wrong pin period. It also writes a new start value a few ticks before a wrap. A design that applied it at once would jump the count instead of finishing the current period. Stopping the timer must freeze both count and pin phase, and a toggle that kept running would show up as a pin change while stopped. Random mixes of tick gaps, gate and mode changes compare the pin against a model. This catches a gate that leaks the wave when the port bit is 0, or a mux that reads the wrong source.

// File: rtl/pfd_div_pkg.sv
package pfd_div_pkg;
  typedef enum logic [1:0] {
    PIN_FROM_PORT = 2'd0,
    PIN_FORCED_LO = 2'd1,
    PIN_FROM_WAVE = 2'd2
  } pin_src_e;

  function automatic pin_src_e pick_src(input logic div_en, input logic port_bit);
    if (!div_en)       return PIN_FROM_PORT;
    else if (port_bit) return PIN_FROM_WAVE;
    else               return PIN_FORCED_LO;
  endfunction
endpackage

// File: rtl/pfd_timer_core.sv
module pfd_timer_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             pre_we,
  input  logic [CNT_W-1:0] pre_data,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] start_q;
  logic             adv;

  assign adv  = run && tick;
  assign wrap = adv && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      start_q <= '0;
    end else begin
      if (pre_we) start_q <= pre_data;
      if (pre_we && !run) begin
        cnt <= pre_data;
      end else if (adv) begin
        if (cnt == CNT_MAX) cnt <= start_q;
        else                cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: wrap reloads the start value held before this edge
  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt == $past(start_q));
  // R2: normal advance
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt != CNT_MAX && !(pre_we && !run)) |=> cnt == $past(cnt) + 1'b1);
  // R2 / R5: no tick or stopped, no write -> hold
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !pre_we) |=> $stable(cnt));
  // R7: stopped write loads the counter
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    (pre_we && !run) |=> cnt == $past(pre_data));
endmodule

// File: rtl/pfd_toggle.sv
module pfd_toggle (
  input  logic clk,
  input  logic rst,
  input  logic flip,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (flip) q <= ~q;
  end

  // R4: each wrap flips the wave
  a_r4_flip: assert property (@(posedge clk) disable iff (rst)
    flip |=> q != $past(q));
  // R5: no wrap, no change
  a_r5_keep: assert property (@(posedge clk) disable iff (rst)
    !flip |=> $stable(q));
endmodule

// File: rtl/pfd_pin_sel.sv
module pfd_pin_sel
  import pfd_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic div_en,
  input  logic port_bit,
  input  logic wave,
  output logic pin
);
  pin_src_e src;
  logic     pin_d;

  always_comb begin
    src = pick_src(div_en, port_bit);
    unique case (src)
      PIN_FROM_PORT: pin_d = port_bit;
      PIN_FROM_WAVE: pin_d = wave;
      PIN_FORCED_LO: pin_d = 1'b0;
      default:       pin_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= pin_d;
  end

  a_r8_plain: assert property (@(posedge clk) disable iff (rst)
    !div_en |=> pin == $past(port_bit));
  a_r9_wave: assert property (@(posedge clk) disable iff (rst)
    (div_en && port_bit) |=> pin == $past(wave));
  a_r10_gate: assert property (@(posedge clk) disable iff (rst)
    (div_en && !port_bit) |=> !pin);
endmodule

// File: rtl/pfd_divider.sv
module pfd_divider #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             div_en,
  input  logic             port_bit,
  input  logic             pre_we,
  input  logic [CNT_W-1:0] pre_data,
  output logic             pin_out,
  output logic [CNT_W-1:0] tmr_count,
  output logic             ovf_pulse
);
  logic wrap;
  logic wave;

  pfd_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .run(run),
    .pre_we(pre_we), .pre_data(pre_data),
    .cnt(tmr_count), .wrap(wrap)
  );

  pfd_toggle u_tgl (
    .clk(clk), .rst(rst), .flip(wrap), .q(wave)
  );

  pfd_pin_sel u_pin (
    .clk(clk), .rst(rst), .div_en(div_en), .port_bit(port_bit),
    .wave(wave), .pin(pin_out)
  );

  always_ff @(posedge clk) begin
    if (rst) ovf_pulse <= 1'b0;
    else     ovf_pulse <= wrap;
  end

  // R3: pulse only after a wrap edge
  a_r3_pulse: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> !ovf_pulse);
  // R1: reset clears outputs
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (tmr_count == '0 && !pin_out && !ovf_pulse));
endmodule

// File: tb/pfd_divider_bench.sv
`timescale 1ns/1ps
module pfd_divider_bench;
  localparam int W = 8;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b0, run = 1'b0, div_en = 1'b0, port_bit = 1'b0, pre_we = 1'b0;
  logic [W-1:0] pre_data = '0;
  logic pin_out, ovf_pulse;
  logic [W-1:0] tmr_count;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pfd_divider #(.CNT_W(W)) u_pfd_divider (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .div_en(div_en),
    .port_bit(port_bit), .pre_we(pre_we), .pre_data(pre_data),
    .pin_out(pin_out), .tmr_count(tmr_count), .ovf_pulse(ovf_pulse)
  );

  // reference model built from the requirements
  logic [W-1:0] m_cnt = '0, m_pre = '0;
  logic m_tgl = 1'b0, m_pin = 1'b0, m_ovf = 1'b0;

  function automatic logic f_wrap(logic [W-1:0] c, logic r, logic t);
    return r && t && (c == MAXV);
  endfunction

  function automatic logic [W-1:0] f_cnt(logic [W-1:0] c, logic [W-1:0] p,
                                         logic r, logic t, logic we, logic [W-1:0] d);
    if (we && !r)  return d;            // R7
    if (!(r && t)) return c;            // R2 R5
    if (c == MAXV) return p;            // R3
    return c + 1'b1;                    // R2
  endfunction

  function automatic logic f_pin(logic de, logic pb, logic tg);
    if (!de) return pb;                 // R8
    return pb & tg;                     // R9 R10
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0; m_pre <= '0; m_tgl <= 1'b0; m_pin <= 1'b0; m_ovf <= 1'b0;
    end else begin
      m_cnt <= f_cnt(m_cnt, m_pre, run, tick, pre_we, pre_data);
      m_pre <= pre_we ? pre_data : m_pre;
      m_tgl <= m_tgl ^ f_wrap(m_cnt, run, tick);
      m_ovf <= f_wrap(m_cnt, run, tick);
      m_pin <= f_pin(div_en, port_bit, m_tgl);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    check(tmr_count == m_cnt, "R2", "count vs model", int'(tmr_count), int'(m_cnt));
    check(ovf_pulse == m_ovf, "R3", "ovf vs model", int'(ovf_pulse), int'(m_ovf));
    check(pin_out == m_pin, "R9", "pin vs model", int'(pin_out), int'(m_pin));
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      cmp_model();
    end
  endtask

  task automatic wait_count(input logic [W-1:0] v);
    for (int i = 0; i < 600 && tmr_count != v; i++) step(1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int per, c0;
    logic p0, prev;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(tmr_count == 0, "R1", "count in reset", int'(tmr_count), 0);
    check(pin_out == 0, "R1", "pin in reset", int'(pin_out), 0);
    check(ovf_pulse == 0, "R1", "ovf in reset", int'(ovf_pulse), 0);
    rst = 1'b0;
    step(2);

    // R7: stopped write loads counter
    pre_we = 1'b1; pre_data = 8'd250;
    step(1);
    pre_we = 1'b0;
    check(tmr_count == 250, "R7", "stopped load", int'(tmr_count), 250);

    // R4: period 2*(256-250)=12
    div_en = 1'b1; port_bit = 1'b1; tick = 1'b1; run = 1'b1;
    prev = pin_out;
    for (int i = 0; i < 100 && !(pin_out && !prev); i++) begin prev = pin_out; step(1); end
    per = 0; prev = 1'b1;
    for (int i = 0; i < 100; i++) begin
      step(1); per++;
      if (pin_out && !prev) break;
      prev = pin_out;
    end
    check(per == 12, "R4", "pin period", per, 12);

    // R3: wrap goes straight to start value
    wait_count(MAXV);
    step(1);
    check(tmr_count == 250, "R3", "reload", int'(tmr_count), 250);
    check(ovf_pulse == 1, "R3", "ovf pulse", int'(ovf_pulse), 1);

    // R5: stop freezes count and pin phase
    run = 1'b0;
    step(2);
    c0 = int'(tmr_count); p0 = pin_out;
    step(20);
    check(int'(tmr_count) == c0, "R5", "count held", int'(tmr_count), c0);
    check(pin_out == p0, "R5", "pin held", int'(pin_out), int'(p0));

    // R6: running write takes effect at next wrap
    run = 1'b1;
    wait_count(8'd252);
    pre_we = 1'b1; pre_data = 8'd100;
    step(1);
    pre_we = 1'b0;
    check(tmr_count == 253, "R6", "no jump on write", int'(tmr_count), 253);
    wait_count(MAXV);
    step(1);
    check(tmr_count == 100, "R6", "new start at wrap", int'(tmr_count), 100);

    // R10: gate low forces pin 0
    port_bit = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step(1);
      check(pin_out == 0, "R10", "gated pin", int'(pin_out), 0);
    end
    // R8: plain port output
    div_en = 1'b0; port_bit = 1'b1;
    step(1);
    check(pin_out == 1, "R8", "plain high", int'(pin_out), 1);
    port_bit = 1'b0;
    step(1);
    check(pin_out == 0, "R8", "plain low", int'(pin_out), 0);

    // random mix, compared against the model every cycle
    for (int i = 0; i < 6000; i++) begin
      tick     = ($urandom % 4) != 0;
      if (($urandom % 64) == 0) run = ~run;
      if (($urandom % 50) == 0) div_en = ~div_en;
      if (($urandom % 30) == 0) port_bit = ~port_bit;
      pre_we   = ($urandom % 40) == 0;
      pre_data = 8'(192 + ($urandom % 64));
      step(1);
    end
    pre_we = 1'b0;
    step(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule